// File: doc/BRIEF.md
# Mixed-Signedness Multiply-Accumulate Unit

This block multiplies two 16-bit operands and folds the product into a 40-bit accumulator. A 5-bit function code, sampled on each cycle where the valid input is high, selects one of three actions: multiply only, which replaces the accumulator; multiply-add; or multiply-subtract. Each operand can be signed or unsigned, and all four combinations are available. A separate group of codes applies rounding to nearest at the 16-bit boundary. This group uses signed operands.

A mode input chooses between integer products and fractional products. A fractional product is doubled before it is accumulated, so that two 1.15 operands give a 1.31 result. The accumulator is presented as three words: an 8-bit guard word and two 16-bit words. A flag reports when the accumulator no longer fits in 32 signed bits. Operand selection and any ALU work happen outside the block.

Top module: `mixmac_top`

## Requirements
- R1: While the active-low reset is low, all accumulator bits and the overflow flag are zero.
- R2: Function code 00000, or any cycle with the valid input low, leaves the accumulator and the overflow flag unchanged.
- R3: Any function code with bit 4 set leaves the accumulator and the overflow flag unchanged.
- R4: Codes 001ab load the accumulator with X*Y. Bit a=1 makes X unsigned and bit b=1 makes Y unsigned; 0 means signed (00 = both signed, 01 = Y unsigned, 10 = X unsigned, 11 = both unsigned).
- R5: Codes 010ab add X*Y to the accumulator, with the same signedness encoding as R4.
- R6: Codes 011ab subtract X*Y from the accumulator, with the same signedness encoding as R4.
- R7: Codes 00001, 00010 and 00011 perform the multiply, add and subtract actions of R4 to R6 with both operands signed, then add 0x8000 to the 40-bit result.
- R8: With the mode input low (fractional), the product is shifted left by one bit before it is used. With the mode input high (integer), the product is used unshifted.
- R9: Each operation that changes the accumulator also sets the overflow flag. The flag is 1 when bits 39 to 31 of the new value are not all equal, and 0 otherwise.
- R10: A result appears on the outputs after the rising edge that accepts the operation. The guard word is bits 39:32, the middle word is bits 31:16 and the low word is bits 15:0.
- R11: All arithmetic wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An operation is presented this cycle |
| funcCode | input | 5 | Function code |
| intMode | input | 1 | 1 = integer products, 0 = fractional (doubled) products |
| xOp | input | 16 | X operand |
| yOp | input | 16 | Y operand |
| accHi | output | 8 | Accumulator bits 39:32 |
| accMid | output | 16 | Accumulator bits 31:16 |
| accLo | output | 16 | Accumulator bits 15:0 |
| macOvf | output | 1 | Accumulator exceeds the signed 32-bit range |

## Verification
The hardest state to reach from the ports is an accumulator that has run past the 32-bit range, or wrapped around the full 40-bit width, and then has to come back. Reaching it needs sequences of products in the same direction. The bench sweeps every function code in both modes over a set of extreme operands (0x8000, 0xFFFF, 0x7FFF and others), and the accumulator carries over from one operation to the next. This drives the guard word through many values and across its own limits. Directed steps then force a fractional overflow, clear it, and wrap below zero.

// File: rtl/mixmac_pkg.sv
package mixmac_pkg;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic doOp;
    logic xSigned;
    logic ySigned;
    logic addAcc;
    logic subAcc;
    logic roundEn;
  } macStrobe_t;
endpackage

// File: rtl/mixmac_ctrl.sv
module mixmac_ctrl
  import mixmac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] funcCode,
  output macStrobe_t        stb
);
  always_comb begin
    stb = '0;
    if (inValid && !funcCode[4]) begin
      case (funcCode[3:2])
        2'b00: begin
          if (funcCode[1:0] != 2'b00) begin
            stb.doOp    = 1'b1;
            stb.xSigned = 1'b1;
            stb.ySigned = 1'b1;
            stb.roundEn = 1'b1;
            stb.addAcc  = (funcCode[1:0] == 2'b10);
            stb.subAcc  = (funcCode[1:0] == 2'b11);
          end
        end
        default: begin
          stb.doOp    = 1'b1;
          stb.xSigned = ~funcCode[1];
          stb.ySigned = ~funcCode[0];
          stb.addAcc  = (funcCode[3:2] == 2'b10);
          stb.subAcc  = (funcCode[3:2] == 2'b11);
        end
      endcase
    end
  end

  // R5
  add_sub_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.addAcc, stb.subAcc}));

  // R7
  round_signed_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.roundEn |-> (stb.xSigned && stb.ySigned && stb.doOp));

  // R3
  upper_codes_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    funcCode[4] |-> !stb.doOp);
endmodule

// File: rtl/mixmac_dp.sv
module mixmac_dp
  import mixmac_pkg::*;
#(
  parameter int OPW    = 16,
  parameter int GUARDW = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  macStrobe_t                 stb,
  input  logic                       intMode,
  input  logic [OPW-1:0]             xOp,
  input  logic [OPW-1:0]             yOp,
  output logic [2*OPW+GUARDW-1:0]    accOut,
  output logic                       ovfOut
);
  localparam int ACCW  = 2*OPW + GUARDW;
  localparam int PRODW = 2*OPW + 2;
  localparam int TOPW  = ACCW - (2*OPW - 1);
  localparam logic [ACCW-1:0] RND_K = ACCW'(1) << (OPW-1);

  logic signed [OPW:0]   xExt, yExt;
  logic signed [PRODW-1:0] prod;
  logic [ACCW-1:0] prodWide, prodUse, base, sum, result;
  logic [ACCW-1:0] accReg;
  logic            ovfReg, nextOvf;
  logic [TOPW-1:0] topBits;

  assign xExt = {stb.xSigned & xOp[OPW-1], xOp};
  assign yExt = {stb.ySigned & yOp[OPW-1], yOp};
  assign prod = xExt * yExt;
  assign prodWide = {{(ACCW-PRODW){prod[PRODW-1]}}, prod};
  assign prodUse  = intMode ? prodWide : (prodWide << 1);
  assign base     = (stb.addAcc || stb.subAcc) ? accReg : '0;
  assign sum      = stb.subAcc ? (base - prodUse) : (base + prodUse);
  assign result   = stb.roundEn ? (sum + RND_K) : sum;
  assign topBits  = result[ACCW-1:2*OPW-1];
  assign nextOvf  = !((&topBits) || !(|topBits));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      ovfReg <= 1'b0;
    end else if (stb.doOp) begin
      accReg <= result;
      ovfReg <= nextOvf;
    end
  end

  assign accOut = accReg;
  assign ovfOut = ovfReg;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (accReg == '0 && !ovfReg));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.doOp |=> ($stable(accReg) && $stable(ovfReg)));

  // R9
  ovf_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfReg == !((&accReg[ACCW-1:2*OPW-1]) || !(|accReg[ACCW-1:2*OPW-1])));

  // R4
  zero_operand_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doOp && !stb.addAcc && !stb.subAcc && !stb.roundEn && xOp == '0)
      |=> (accReg == '0 && !ovfReg));
endmodule

// File: rtl/mixmac_top.sv
module mixmac_top
  import mixmac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [4:0]  funcCode,
  input  logic        intMode,
  input  logic [15:0] xOp,
  input  logic [15:0] yOp,
  output logic [7:0]  accHi,
  output logic [15:0] accMid,
  output logic [15:0] accLo,
  output logic        macOvf
);
  localparam int OPW    = 16;
  localparam int GUARDW = 8;
  localparam int ACCW   = 2*OPW + GUARDW;

  macStrobe_t      stb;
  logic [ACCW-1:0] accWord;

  mixmac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcCode(funcCode), .stb(stb)
  );

  mixmac_dp #(.OPW(OPW), .GUARDW(GUARDW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .intMode(intMode),
    .xOp(xOp), .yOp(yOp), .accOut(accWord), .ovfOut(macOvf)
  );

  // R10
  assign accHi  = accWord[ACCW-1:2*OPW];
  assign accMid = accWord[2*OPW-1:OPW];
  assign accLo  = accWord[OPW-1:0];

  // R2
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(accHi) && $stable(accMid) && $stable(accLo) && $stable(macOvf)));
endmodule

// File: tb/mixmac_top_tb_top.sv
module mixmac_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [4:0] funcCode = '0;
  logic intMode = 1'b0;
  logic [15:0] xOp = '0, yOp = '0;
  logic [7:0] accHi;
  logic [15:0] accMid, accLo;
  logic macOvf;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [39:0] mAcc = '0;
  logic mOvf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixmac_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcCode(funcCode),
    .intMode(intMode), .xOp(xOp), .yOp(yOp),
    .accHi(accHi), .accMid(accMid), .accLo(accLo), .macOvf(macOvf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string tagOf(input logic [4:0] c, input logic v);
    if (!v || c == 5'd0) return "R2";
    if (c[4]) return "R3";
    case (c[3:2])
      2'b00: return "R7";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Arithmetic reference for R4-R9, R11
  task automatic modelStep(input logic v, input logic [4:0] c, input logic im,
                           input logic [15:0] x, input logic [15:0] y);
    logic xs, ys, rnd;
    int mode;
    longint xe, ye, p, r;
    logic [39:0] res;
    if (!v || c == 5'd0 || c[4]) return;
    rnd = (c[3:2] == 2'b00);
    if (rnd) begin
      xs = 1'b1; ys = 1'b1;
      mode = (c[1:0] == 2'b01) ? 0 : (c[1:0] == 2'b10) ? 1 : 2;
    end else begin
      xs = ~c[1]; ys = ~c[0];
      mode = (c[3:2] == 2'b01) ? 0 : (c[3:2] == 2'b10) ? 1 : 2;
    end
    xe = xs ? longint'($signed(x)) : longint'(x);
    ye = ys ? longint'($signed(y)) : longint'(y);
    p = xe * ye;
    if (!im) p = p * 2;
    if (mode == 1)      r = longint'(mAcc) + p;
    else if (mode == 2) r = longint'(mAcc) - p;
    else                r = p;
    if (rnd) r = r + 32768;
    res = r[39:0];
    mAcc = res;
    mOvf = !(res[39:31] == 9'h000 || res[39:31] == 9'h1FF);
  endtask

  task automatic checkOut(input string tag);
    logic [39:0] got;
    got = {accHi, accMid, accLo};
    checks = checks + 1;
    if (got !== mAcc || macOvf !== mOvf) begin
      failures = failures + 1;
      $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", tag, got, macOvf, mAcc, mOvf);
    end
  endtask

  // R10: drive at negedge, result checked at the next negedge
  task automatic doOp(input logic v, input logic [4:0] c, input logic im,
                      input logic [15:0] x, input logic [15:0] y);
    inValid = v; funcCode = c; intMode = im; xOp = x; yOp = y;
    modelStep(v, c, im, x, y);
    @(negedge clk);
    checkOut(tagOf(c, v));
  endtask

  logic [15:0] pats [8];

  initial begin
    pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h7FFF; pats[3] = 16'h8000;
    pats[4] = 16'hFFFF; pats[5] = 16'h1234; pats[6] = 16'hC001; pats[7] = 16'h0002;

    // R1: reset state
    repeat (3) @(negedge clk);
    checkOut("R1");
    rstN = 1'b1;
    @(negedge clk);

    // R8: sweep both modes, all codes, operand pairs (R4 R5 R6 R7 R3 R2 R9 R11)
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 32; c++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            doOp(1'b1, 5'(c), m[0], pats[i], pats[j]);

    // R2: valid low with an accumulate code presented
    for (int k = 0; k < 4; k++) doOp(1'b0, 5'b01000, 1'b1, 16'h7FFF, 16'h7FFF);

    // R1: reset in mid-run clears accumulator and flag
    rstN = 1'b0;
    mAcc = '0; mOvf = 1'b0;
    @(negedge clk);
    checkOut("R1");
    rstN = 1'b1;
    @(negedge clk);

    // R9/R8: fractional 0x8000*0x8000 gives 0x0080000000 with overflow
    doOp(1'b1, 5'b00100, 1'b0, 16'h8000, 16'h8000);
    checks = checks + 1;
    if ({accHi, accMid, accLo} !== 40'h0080000000 || macOvf !== 1'b1) begin
      failures = failures + 1;
      $display("FAIL R9: acc=%h ovf=%b expected acc=0080000000 ovf=1",
               {accHi, accMid, accLo}, macOvf);
    end
    // R9: flag clears on the next in-range result
    doOp(1'b1, 5'b00100, 1'b1, 16'h0001, 16'h0001);
    // R11: 1 - 2 wraps to all ones, no overflow
    doOp(1'b1, 5'b01100, 1'b1, 16'h0002, 16'h0001);
    checks = checks + 1;
    if ({accHi, accMid, accLo} !== 40'hFFFFFFFFFF || macOvf !== 1'b0) begin
      failures = failures + 1;
      $display("FAIL R11: acc=%h ovf=%b expected acc=ffffffffff ovf=0",
               {accHi, accMid, accLo}, macOvf);
    end
    // R7: rounding on a zero product yields 0x8000
    doOp(1'b1, 5'b00001, 1'b1, 16'h0000, 16'h1234);
    checks = checks + 1;
    if ({accHi, accMid, accLo} !== 40'h0000008000) begin
      failures = failures + 1;
      $display("FAIL R7: acc=%h expected acc=0000008000", {accHi, accMid, accLo});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule